// File: doc/BRIEF.md
# Alternating Two-Three Clock Divider

This block derives a slower clock from a fast one at a ratio of two and a half. A true half-integer ratio cannot be reached with rising-edge logic alone, so the block alternates between an output period of two input cycles and one of three input cycles. Two output periods therefore fit into every five input cycles. A 100 MHz input gives a 40 MHz average output whose periods alternate between 20 ns and 30 ns.

A frame counter steps through the five input cycles of each pair of output periods. A decoder maps the frame position to the next output level and to an edge marker. Both are registered, so the divided clock and its edge strobe come straight from flip-flops. Downstream logic can use the divided clock as a level. It can also use the one-cycle strobe as a clock enable in the fast domain.

Two parameters fix the waveform when the block is built. One selects whether the short period or the long period comes first after reset. The other selects whether the long period is high for one cycle or for two.

Top module: `alt_div`

## Requirements
- R1: While reset is sampled high at a rising clock edge, both `clk_div` and `rise_pulse` are low after that edge, and the frame restarts at its first position.
- R2: The first rising edge of `clk_div`, together with a `rise_pulse`, appears on the first clock edge that samples reset low.
- R3: Outside reset, `clk_div` rises exactly twice in every five input cycles. The gaps between successive rises alternate between 2 and 3 input cycles, so a 100 MHz input yields a 40 MHz average with 20 ns and 30 ns periods.
- R4: In the two-cycle period, `clk_div` is high for one input cycle and low for one.
- R5: In the three-cycle period, `clk_div` is high for one cycle and low for two when `LONG_WIDE_HIGH`=0, and high for two and low for one when `LONG_WIDE_HIGH`=1.
- R6: With `FIRST_SHORT`=1 the first period after reset is the two-cycle period. With `FIRST_SHORT`=0 it is the three-cycle period.
- R7: `rise_pulse` is high for exactly one input cycle. It is high in exactly those cycles where `clk_div` has just changed from 0 to 1.
- R8: A reset sampled at an edge where a rising edge of `clk_div` was due takes priority: both outputs stay low. After reset is released the waveform starts again from the beginning of the frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast input clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| clk_div | output | 1 | Divided clock, registered, average ratio 2.5 |
| rise_pulse | output | 1 | One-cycle strobe marking each rising edge of `clk_div` |

## Verification
Reset and a scheduled rising edge of the divided clock can fall on the same clock edge. The bench provokes this by raising reset just before the frame position where a rise is due, both at the frame start and inside the frame. It judges the result by requiring both outputs to be low after that edge. It then requires the full frame waveform to restart from its first position on the first edge after release. All four parameter variants run side by side against a table of per-cycle expected levels and strobes, so the ordering and high-time options are compared cycle for cycle.

// File: rtl/alt_div_pkg.sv
package alt_div_pkg;

   // Number of high cycles in a period of len cycles: the larger half when wide
   function automatic int high_cycles(int len, bit wide);
      return wide ? (len + 1) / 2 : len / 2;
   endfunction

endpackage

// File: rtl/alt_div_frame_ctr.sv
module alt_div_frame_ctr #(
   parameter int FRAME = 5,
   parameter int CW    = 3
) (
   input  logic          clk,
   input  logic          rst,
   output logic [CW-1:0] pos
);
   localparam logic [CW-1:0] LAST = CW'(FRAME - 1);

   always_ff @(posedge clk) begin
      if (rst)
         pos <= '0;
      else if (pos == LAST)
         pos <= '0;
      else
         pos <= pos + 1'b1;
   end
endmodule

// File: rtl/alt_div_phase.sv
module alt_div_phase #(
   parameter int SHORT_CYC      = 2,
   parameter int LONG_CYC       = 3,
   parameter bit FIRST_SHORT    = 1'b1,
   parameter bit LONG_WIDE_HIGH = 1'b0,
   parameter int CW             = 3
) (
   input  logic [CW-1:0] pos,
   output logic          level_d,
   output logic          edge_d
);
   localparam int SHORT_HI = alt_div_pkg::high_cycles(SHORT_CYC, 1'b0);
   localparam int LONG_HI  = alt_div_pkg::high_cycles(LONG_CYC, LONG_WIDE_HIGH);

   logic [CW-1:0] second_start;
   logic [CW-1:0] first_hi_end;
   logic [CW-1:0] second_hi_end;

   generate
      if (FIRST_SHORT) begin : g_short_first
         assign second_start  = CW'(SHORT_CYC);
         assign first_hi_end  = CW'(SHORT_HI);
         assign second_hi_end = CW'(SHORT_CYC + LONG_HI);
      end else begin : g_long_first
         assign second_start  = CW'(LONG_CYC);
         assign first_hi_end  = CW'(LONG_HI);
         assign second_hi_end = CW'(LONG_CYC + SHORT_HI);
      end
   endgenerate

   always_comb begin
      level_d = (pos < first_hi_end) ||
                ((pos >= second_start) && (pos < second_hi_end));
      edge_d  = (pos == '0) || (pos == second_start);
   end
endmodule

// File: rtl/alt_div_out_reg.sv
module alt_div_out_reg (
   input  logic clk,
   input  logic rst,
   input  logic level_d,
   input  logic edge_d,
   output logic clk_div,
   output logic rise_pulse
);
   always_ff @(posedge clk) begin
      if (rst) begin
         clk_div    <= 1'b0;
         rise_pulse <= 1'b0;
      end else begin
         clk_div    <= level_d;
         rise_pulse <= edge_d;
      end
   end
endmodule

// File: rtl/alt_div.sv
module alt_div #(
   parameter int SHORT_CYC      = 2,
   parameter int LONG_CYC       = 3,
   parameter bit FIRST_SHORT    = 1'b1,
   parameter bit LONG_WIDE_HIGH = 1'b0
) (
   input  logic clk,
   input  logic rst,
   output logic clk_div,
   output logic rise_pulse
);
   localparam int FRAME = SHORT_CYC + LONG_CYC;
   localparam int CW    = $clog2(FRAME);

   generate
      if (SHORT_CYC < 2) begin : g_bad_short
         $error("alt_div: SHORT_CYC must be at least 2");
      end
      if (LONG_CYC <= SHORT_CYC) begin : g_bad_long
         $error("alt_div: LONG_CYC must exceed SHORT_CYC");
      end
   endgenerate

   logic [CW-1:0] pos;
   logic          level_d;
   logic          edge_d;

   alt_div_frame_ctr #(.FRAME(FRAME), .CW(CW)) u_ctr (
      .clk (clk),
      .rst (rst),
      .pos (pos)
   );

   alt_div_phase #(
      .SHORT_CYC      (SHORT_CYC),
      .LONG_CYC       (LONG_CYC),
      .FIRST_SHORT    (FIRST_SHORT),
      .LONG_WIDE_HIGH (LONG_WIDE_HIGH),
      .CW             (CW)
   ) u_phase (
      .pos     (pos),
      .level_d (level_d),
      .edge_d  (edge_d)
   );

   alt_div_out_reg u_out (
      .clk        (clk),
      .rst        (rst),
      .level_d    (level_d),
      .edge_d     (edge_d),
      .clk_div    (clk_div),
      .rise_pulse (rise_pulse)
   );
endmodule

// File: rtl/alt_div_chk.sv
module alt_div_chk #(
   parameter int SHORT_CYC      = 2,
   parameter int LONG_CYC       = 3,
   parameter bit LONG_WIDE_HIGH = 1'b0
) (
   input logic clk,
   input logic rst,
   input logic clk_div,
   input logic rise_pulse
);
   localparam int GW       = $clog2(LONG_CYC + 2) + 1;
   localparam int SHORT_HI = alt_div_pkg::high_cycles(SHORT_CYC, 1'b0);
   localparam int LONG_HI  = alt_div_pkg::high_cycles(LONG_CYC, LONG_WIDE_HIGH);

   logic [GW-1:0] gap;
   logic [GW-1:0] last_gap;
   logic [GW-1:0] hrun;
   logic          seen1;
   logic          seen2;
   logic          rst_q = 1'b0;

   always_ff @(posedge clk) begin
      rst_q <= rst;
      // R1: outputs low after an edge that sampled reset
      if (rst_q) begin
         p_reset_low_r1: assert (!clk_div && !rise_pulse)
            else $error("reset did not clear outputs");
      end
      if (rst) begin
         gap      <= '0;
         last_gap <= '0;
         hrun     <= '0;
         seen1    <= 1'b0;
         seen2    <= 1'b0;
      end else begin
         if (rise_pulse) begin
            if (seen1) begin
               p_gap_len_r3: assert (gap == GW'(SHORT_CYC) || gap == GW'(LONG_CYC))
                  else $error("rise spacing %0d", gap);
            end
            if (seen2) begin
               p_alternate_r3: assert (gap != last_gap)
                  else $error("periods did not alternate");
            end
            last_gap <= gap;
            gap      <= GW'(1);
            seen1    <= 1'b1;
            seen2    <= seen1;
         end else if (gap != '1) begin
            gap <= gap + 1'b1;
         end
         if (clk_div) begin
            if (hrun != '1) hrun <= hrun + 1'b1;
         end else begin
            if (hrun != '0) begin
               // R4 and R5: high time of each period
               p_high_len_r5: assert (hrun == GW'(SHORT_HI) || hrun == GW'(LONG_HI))
                  else $error("high run %0d", hrun);
            end
            hrun <= '0;
         end
      end
   end

   p_first_rise_r2: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |=> rise_pulse);

   p_pulse_single_r7: assert property (@(posedge clk) disable iff (rst)
      rise_pulse |=> !rise_pulse);

   p_pulse_edge_r7: assert property (@(posedge clk) disable iff (rst)
      rise_pulse |-> (clk_div && !$past(clk_div)));

   p_edge_has_pulse_r7: assert property (@(posedge clk) disable iff (rst)
      (clk_div && !$past(clk_div)) |-> rise_pulse);
endmodule

bind alt_div alt_div_chk #(
   .SHORT_CYC      (SHORT_CYC),
   .LONG_CYC       (LONG_CYC),
   .LONG_WIDE_HIGH (LONG_WIDE_HIGH)
) u_chk (
   .clk        (clk),
   .rst        (rst),
   .clk_div    (clk_div),
   .rise_pulse (rise_pulse)
);

// File: tb/sim_alt_div.sv
module sim_alt_div;
   logic clk = 1'b0;
   logic rst = 1'b1;
   always #10 clk = ~clk;

   logic [3:0] div;
   logic [3:0] pul;

   // u0: short first, narrow long; u1: short first, wide long;
   // u2: long first, narrow long; u3: long first, wide long
   alt_div u0 (.clk(clk), .rst(rst), .clk_div(div[0]), .rise_pulse(pul[0]));
   alt_div #(.LONG_WIDE_HIGH(1'b1)) u1 (.clk(clk), .rst(rst), .clk_div(div[1]), .rise_pulse(pul[1]));
   alt_div #(.FIRST_SHORT(1'b0)) u2 (.clk(clk), .rst(rst), .clk_div(div[2]), .rise_pulse(pul[2]));
   alt_div #(.FIRST_SHORT(1'b0), .LONG_WIDE_HIGH(1'b1)) u3 (.clk(clk), .rst(rst), .clk_div(div[3]), .rise_pulse(pul[3]));

   // Per frame cycle after reset release: {expected div[3:0], expected pul[3:0]}
   localparam logic [7:0] FRAME_TBL [5] = '{
      8'b1111_1111,
      8'b1000_0000,
      8'b0011_0011,
      8'b1110_1100,
      8'b0000_0000
   };

   int  errors = 0;
   int  checks = 0;
   bit  done   = 1'b0;
   int  rises [4];

   task automatic check4(string tag, logic [3:0] got, logic [3:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s got=%b expected=%b", tag, got, exp);
      end
   endtask

   task automatic check_int(string tag, int got, int exp);
      checks++;
      if (got != exp) begin
         errors++;
         $display("FAIL %s got=%0d expected=%0d", tag, got, exp);
      end
   endtask

   // Walk n cycles of the frame table starting right after reset release
   task automatic run_frames(int n);
      logic [3:0] prev = 4'b0000;
      for (int k = 0; k < n; k++) begin
         @(negedge clk);
         if (k == 0) check4("R2 first rise after release", pul, 4'b1111);
         check4("R3 R4 R5 R6 divided level", div, FRAME_TBL[k % 5][7:4]);
         check4("R7 strobe pattern", pul, FRAME_TBL[k % 5][3:0]);
         check4("R7 strobe equals rising edge", pul, div & ~prev);
         for (int u = 0; u < 4; u++) if (div[u] && !prev[u]) rises[u]++;
         prev = div;
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check4("R1 level held in reset", div, 4'b0000);
      check4("R1 strobe held in reset", pul, 4'b0000);

      for (int u = 0; u < 4; u++) rises[u] = 0;
      rst = 1'b0;
      run_frames(15);
      for (int u = 0; u < 4; u++) check_int("R3 six rises in fifteen cycles", rises[u], 6);

      // R8: reset lands on the frame start, where every variant schedules a rise
      rst = 1'b1;
      @(negedge clk);
      check4("R8 reset beats rise level", div, 4'b0000);
      check4("R8 reset beats rise strobe", pul, 4'b0000);
      rst = 1'b0;
      run_frames(5);

      // R8: reset lands on position 3, where the long-first variants schedule a rise
      run_frames(3);
      rst = 1'b1;
      @(negedge clk);
      check4("R8 mid-frame reset level", div, 4'b0000);
      check4("R8 mid-frame reset strobe", pul, 4'b0000);
      @(negedge clk);
      check4("R1 reset held two cycles", div | pul, 4'b0000);
      rst = 1'b0;
      run_frames(5);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired got=running expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule